// File: doc/BRIEF.md
# Limited-Pointer Directory Entry Controller

This block keeps the coherence record for one memory block in a distributed shared-memory machine. The record holds a small set of hardware sharer pointers (node IDs), a protocol state, a meta-state flag and an acknowledgement counter. Read requests add the requesting node to the pointer set. A write starts a write transaction: the controller sends one invalidation to each recorded sharer, counts the acknowledgements that come back, and then grants exclusive ownership to the writer.

When a new reader arrives and every pointer is already taken, the controller does not evict a sharer. It raises a trap to the local processor and stalls. The handler reads the pointer contents from the directory view ports and moves them into its own full-map vector. It then signals `trap_done`, which empties the pointers and arms trap-on-write. While that mode is armed, a write traps as well. The handler finishes that write through the termination port. It supplies the requester and the number of invalidations it sent itself. The controller loads that count, returns to normal mode and waits for the acknowledgements.

Requests, responses and invalidations are valid/ready streams. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low while a response waits to be taken, while a trap is pending, and in the cycle a write transaction completes. `rsp_*` and `inv_*` hold their payload stable while valid is high and ready is low. A producer may therefore stall either stream for any number of cycles. Trap, termination and acknowledgement pins are plain single-cycle strobes.

Top module: `lpdir_entry_ctrl`

## Requirements
- R1: A read from a node not yet recorded, with a free pointer, stores the node in the lowest free pointer slot. It returns a read grant (`rsp_kind` 0) to that node.
- R2: A read from a node already held in a pointer returns a read grant and uses no new pointer. A later read from a new node therefore still finds the free slot it would have found without the duplicate.
- R3: A read from a new node while all NPTR pointers are valid returns no response. Instead it raises `trap_req` with `trap_cause` 0 and `trap_node` set to the reader. The pointer contents stay visible on `dir_ptrs`/`dir_vld`, and `req_ready` stays low until the handler answers.
- R4: `trap_done` during a trap empties all pointers, sets `meta_tow`, drops `trap_req` and resumes request service. Later reads allocate pointers again, and a further overflow traps again.
- R5: With `meta_tow` set, a write request raises `trap_req` with `trap_cause` 1 and `trap_node` set to the writer, and returns no response.
- R6: `term_valid` during a trap empties the pointers and records `term_node` as requester. It loads the acknowledgement counter with `term_count` and clears `meta_tow`. It then grants the write (`rsp_kind` 1) to `term_node` once that many acknowledgements have arrived; a count of 0 grants without any acknowledgement.
- R7: A write in the shared state with `meta_tow` clear empties the pointers. It issues one invalidation per valid pointer, lowest slot first, and grants the write only after all of them are issued and as many acknowledgements have arrived.
- R8: Any request accepted during a write transaction gets a busy response (`rsp_kind` 2) to its node. It changes nothing: the pending grant still needs exactly the remaining acknowledgements.
- R9: In the exclusive state, a request from the owner is granted at once with the kind it asked for. A request from another node sends one invalidation to the owner and, after one acknowledgement, grants the new node. A read leaves the entry shared with that node as the only pointer, and a write makes that node the new owner.
- R10: `rsp_valid`/`rsp_node` and `inv_valid`/`inv_node` stay stable while their ready is low. `req_ready` is low while a response is waiting.
- R11: After reset no pointer is valid, `meta_tow`, `trap_req`, `rsp_valid` and `inv_valid` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_node | input | NODE_W | Requesting node ID |
| req_write | input | 1 | 1 = write request, 0 = read request |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with valid |
| rsp_kind | output | 2 | 0 read grant, 1 write grant, 2 busy |
| rsp_node | output | NODE_W | Destination node of the response |
| inv_valid | output | 1 | Invalidation valid |
| inv_ready | input | 1 | Invalidation taken when high with valid |
| inv_node | output | NODE_W | Node to invalidate |
| ack_valid | input | 1 | One invalidation acknowledgement |
| trap_req | output | 1 | Trap to local processor pending |
| trap_cause | output | 1 | 0 pointer overflow on read, 1 write under trap-on-write |
| trap_node | output | NODE_W | Node whose request trapped |
| trap_done | input | 1 | Handler finished an overflow trap |
| term_valid | input | 1 | Handler terminates a trapped write |
| term_node | input | NODE_W | Requester recorded on termination |
| term_count | input | CNT_W | Number of acknowledgements to await |
| dir_vld | output | NPTR | Pointer valid bits |
| dir_ptrs | output | NPTR*NODE_W | Pointer contents, slot 0 in the low bits |
| meta_tow | output | 1 | Trap-on-write meta-state armed |

## Verification
The hardest situation to reach from the ports is the one where the bookkeeping must survive repeated software intervention. A second overflow comes after a handled first one, and a trapped write then finishes through termination while stray requests arrive mid-transaction. The stimulus fills the pointer set with a small pool of nodes so that overflows and duplicates occur often. A seeded random mix of reads and writes then walks through overflow, trap-on-write, termination with random counts, exclusive handover and hardware invalidation rounds. A bench model of the pointer set and mode predicts each trap, invalidation count and grant.

// File: rtl/lpdir_pkg.sv
package lpdir_pkg;

  typedef enum logic [1:0] {
    ST_SHARED = 2'd0,
    ST_WT     = 2'd1,
    ST_EXCL   = 2'd2,
    ST_TRAP   = 2'd3
  } dir_st_t;

  localparam logic [1:0] RSP_RD   = 2'd0;
  localparam logic [1:0] RSP_WR   = 2'd1;
  localparam logic [1:0] RSP_BUSY = 2'd2;

  localparam logic CAUSE_OVF = 1'b0;
  localparam logic CAUSE_WR  = 1'b1;

endpackage

// File: rtl/lpdir_ptr_file.sv
module lpdir_ptr_file #(
  parameter int NODE_W = 6,
  parameter int NPTR   = 4,
  parameter int CNT_W  = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     alloc,
  input  logic [NODE_W-1:0]        alloc_node,
  input  logic [NODE_W-1:0]        look_node,
  output logic                     hit,
  output logic                     full,
  output logic [CNT_W-1:0]         nvalid,
  output logic [NPTR-1:0]          vld,
  output logic [NPTR*NODE_W-1:0]   ptrs_flat
);
  localparam int IDX_W = (NPTR > 1) ? $clog2(NPTR) : 1;

  logic [NODE_W-1:0] ptr_q [NPTR];
  logic [NPTR-1:0]   vld_q;
  logic [NPTR-1:0]   match;
  logic [IDX_W-1:0]  free_idx;

  for (genvar g = 0; g < NPTR; g++) begin : g_slot
    assign match[g] = vld_q[g] && (ptr_q[g] == look_node);
    assign ptrs_flat[g*NODE_W +: NODE_W] = ptr_q[g];
  end

  always_comb begin
    free_idx = '0;
    for (int i = NPTR - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    nvalid = '0;
    for (int i = 0; i < NPTR; i++) nvalid = nvalid + CNT_W'(vld_q[i]);
  end

  assign hit  = |match;
  assign full = &vld_q;
  assign vld  = vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NPTR; i++) ptr_q[i] <= '0;
    end else if (clr) begin
      vld_q <= '0;
    end else if (alloc) begin
      vld_q[free_idx] <= 1'b1;
      ptr_q[free_idx] <= alloc_node;
    end
  end

  // R1: the controller never asks for a slot when none is free
  p_alloc_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !full);
  // R4: emptying leaves no valid pointer
  p_clr_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld == '0));
  // R2: an allocation adds exactly one valid pointer
  p_alloc_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !clr) |=> ($countones(vld) == $countones($past(vld)) + 1));

endmodule

// File: rtl/lpdir_inv_issue.sv
module lpdir_inv_issue #(
  parameter int NODE_W = 6,
  parameter int NPTR   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [NPTR-1:0]        load_mask,
  input  logic [NPTR*NODE_W-1:0] load_nodes,
  output logic                   inv_valid,
  input  logic                   inv_ready,
  output logic [NODE_W-1:0]      inv_node,
  output logic                   idle
);
  localparam int IDX_W = (NPTR > 1) ? $clog2(NPTR) : 1;

  logic [NPTR-1:0]   mask_q;
  logic [NODE_W-1:0] node_q [NPTR];
  logic [IDX_W-1:0]  pick;

  always_comb begin
    pick = '0;
    for (int i = NPTR - 1; i >= 0; i--) begin
      if (mask_q[i]) pick = IDX_W'(i);
    end
  end

  assign inv_valid = |mask_q;
  assign inv_node  = node_q[pick];
  assign idle      = ~|mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      for (int i = 0; i < NPTR; i++) node_q[i] <= '0;
    end else if (load) begin
      mask_q <= load_mask;
      for (int i = 0; i < NPTR; i++) node_q[i] <= load_nodes[i*NODE_W +: NODE_W];
    end else if (inv_valid && inv_ready) begin
      mask_q[pick] <= 1'b0;
    end
  end

  // R10: an offered invalidation holds until it is taken
  p_inv_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !inv_ready && !load) |=> (inv_valid && $stable(inv_node)));
  // R7: each handshake retires exactly one pending invalidation
  p_inv_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_ready && !load) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));

endmodule

// File: rtl/lpdir_ack_ctr.sv
module lpdir_ack_ctr #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (dec && !zero) cnt_q <= cnt_q - 1'b1;
  end

  // R6: each acknowledgement removes one from a nonzero count
  p_ack_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R8: without load or acknowledgement the count holds
  p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/lpdir_entry_ctrl.sv
module lpdir_entry_ctrl
  import lpdir_pkg::*;
#(
  parameter int NODE_W = 6,
  parameter int NPTR   = 4,
  parameter int NODES  = 2 ** NODE_W,
  parameter int CNT_W  = $clog2(NODES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [NODE_W-1:0]      req_node,
  input  logic                   req_write,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [1:0]             rsp_kind,
  output logic [NODE_W-1:0]      rsp_node,
  output logic                   inv_valid,
  input  logic                   inv_ready,
  output logic [NODE_W-1:0]      inv_node,
  input  logic                   ack_valid,
  output logic                   trap_req,
  output logic                   trap_cause,
  output logic [NODE_W-1:0]      trap_node,
  input  logic                   trap_done,
  input  logic                   term_valid,
  input  logic [NODE_W-1:0]      term_node,
  input  logic [CNT_W-1:0]       term_count,
  output logic [NPTR-1:0]        dir_vld,
  output logic [NPTR*NODE_W-1:0] dir_ptrs,
  output logic                   meta_tow
);

  dir_st_t           state;
  logic              meta_q;
  logic [NODE_W-1:0] holder;
  logic              pend_read;
  logic              rsp_valid_q;
  logic [1:0]        rsp_kind_q;
  logic [NODE_W-1:0] rsp_node_q;
  logic              trap_q;
  logic              trap_cause_q;
  logic [NODE_W-1:0] trap_node_q;

  logic              hit, full, inv_idle, ack_zero, done, acc;
  logic [CNT_W-1:0]  nvalid;
  logic [NPTR-1:0]   vld;
  logic [NPTR*NODE_W-1:0] ptrs_flat;

  logic              ptr_clr, ptr_alloc;
  logic [NODE_W-1:0] alloc_node;
  logic              inv_load;
  logic [NPTR-1:0]   inv_mask;
  logic [NPTR*NODE_W-1:0] inv_nodes;
  logic              ack_load;
  logic [CNT_W-1:0]  ack_val;

  assign done      = (state == ST_WT) && inv_idle && ack_zero && !rsp_valid_q;
  assign req_ready = !rsp_valid_q && (state != ST_TRAP) && !done;
  assign acc       = req_valid && req_ready;

  always_comb begin
    ptr_clr    = 1'b0;
    ptr_alloc  = 1'b0;
    alloc_node = req_node;
    inv_load   = 1'b0;
    inv_mask   = '0;
    inv_nodes  = ptrs_flat;
    ack_load   = 1'b0;
    ack_val    = '0;
    unique case (state)
      ST_SHARED: if (acc) begin
        if (!req_write) begin
          ptr_alloc = !hit && !full;
        end else if (!meta_q) begin
          ptr_clr  = 1'b1;
          inv_load = 1'b1;
          inv_mask = vld;
          ack_load = 1'b1;
          ack_val  = nvalid;
        end
      end
      ST_EXCL: if (acc && (req_node != holder)) begin
        inv_load  = 1'b1;
        inv_mask  = NPTR'(1);
        inv_nodes = {NPTR{holder}};
        ack_load  = 1'b1;
        ack_val   = CNT_W'(1);
      end
      ST_WT: if (done && pend_read) begin
        ptr_alloc  = 1'b1;
        alloc_node = holder;
      end
      ST_TRAP: begin
        if (term_valid) begin
          ptr_clr  = 1'b1;
          ack_load = 1'b1;
          ack_val  = term_count;
        end else if (trap_done) begin
          ptr_clr = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_SHARED;
      meta_q       <= 1'b0;
      holder       <= '0;
      pend_read    <= 1'b0;
      rsp_valid_q  <= 1'b0;
      rsp_kind_q   <= RSP_RD;
      rsp_node_q   <= '0;
      trap_q       <= 1'b0;
      trap_cause_q <= CAUSE_OVF;
      trap_node_q  <= '0;
    end else begin
      if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;
      unique case (state)
        ST_SHARED: if (acc) begin
          if (!req_write) begin
            if (hit || !full) begin
              rsp_valid_q <= 1'b1;
              rsp_kind_q  <= RSP_RD;
              rsp_node_q  <= req_node;
            end else begin
              trap_q       <= 1'b1;
              trap_cause_q <= CAUSE_OVF;
              trap_node_q  <= req_node;
              state        <= ST_TRAP;
            end
          end else if (meta_q) begin
            trap_q       <= 1'b1;
            trap_cause_q <= CAUSE_WR;
            trap_node_q  <= req_node;
            state        <= ST_TRAP;
          end else begin
            holder    <= req_node;
            pend_read <= 1'b0;
            state     <= ST_WT;
          end
        end
        ST_EXCL: if (acc) begin
          if (req_node == holder) begin
            rsp_valid_q <= 1'b1;
            rsp_kind_q  <= req_write ? RSP_WR : RSP_RD;
            rsp_node_q  <= req_node;
          end else begin
            holder    <= req_node;
            pend_read <= !req_write;
            state     <= ST_WT;
          end
        end
        ST_WT: begin
          if (done) begin
            rsp_valid_q <= 1'b1;
            rsp_kind_q  <= pend_read ? RSP_RD : RSP_WR;
            rsp_node_q  <= holder;
            state       <= pend_read ? ST_SHARED : ST_EXCL;
          end else if (acc) begin
            rsp_valid_q <= 1'b1;
            rsp_kind_q  <= RSP_BUSY;
            rsp_node_q  <= req_node;
          end
        end
        ST_TRAP: begin
          if (term_valid) begin
            trap_q    <= 1'b0;
            holder    <= term_node;
            pend_read <= 1'b0;
            meta_q    <= 1'b0;
            state     <= ST_WT;
          end else if (trap_done) begin
            trap_q <= 1'b0;
            meta_q <= 1'b1;
            state  <= ST_SHARED;
          end
        end
        default: state <= ST_SHARED;
      endcase
    end
  end

  lpdir_ptr_file #(.NODE_W(NODE_W), .NPTR(NPTR), .CNT_W(CNT_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .alloc(ptr_alloc),
    .alloc_node(alloc_node), .look_node(req_node), .hit(hit), .full(full),
    .nvalid(nvalid), .vld(vld), .ptrs_flat(ptrs_flat)
  );

  lpdir_inv_issue #(.NODE_W(NODE_W), .NPTR(NPTR)) u_inv (
    .clk(clk), .rst_n(rst_n), .load(inv_load), .load_mask(inv_mask),
    .load_nodes(inv_nodes), .inv_valid(inv_valid), .inv_ready(inv_ready),
    .inv_node(inv_node), .idle(inv_idle)
  );

  lpdir_ack_ctr #(.CNT_W(CNT_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .load(ack_load), .load_val(ack_val),
    .dec(ack_valid && (state == ST_WT)), .zero(ack_zero)
  );

  assign rsp_valid  = rsp_valid_q;
  assign rsp_kind   = rsp_kind_q;
  assign rsp_node   = rsp_node_q;
  assign trap_req   = trap_q;
  assign trap_cause = trap_cause_q;
  assign trap_node  = trap_node_q;
  assign dir_vld    = vld;
  assign dir_ptrs   = ptrs_flat;
  assign meta_tow   = meta_q;

  // R3: a read from a new node into a full pointer set traps
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHARED && acc && !req_write && !hit && full)
    |=> (trap_req && trap_cause == CAUSE_OVF && !rsp_valid));
  // R4: handled overflow arms trap-on-write
  p_meta_tow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRAP && trap_done && !term_valid) |=> (meta_tow && !trap_req));
  // R8: a request during a write transaction only gets busy
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WT && acc) |=> (state == ST_WT && rsp_valid && rsp_kind == RSP_BUSY));
  // R7: write grant only after invalidations drained and acks counted
  p_grant_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(rsp_valid) && rsp_kind == RSP_WR && $past(state) == ST_WT)
    |-> ($past(ack_zero) && $past(inv_idle)));
  // R10: a waiting response holds still and blocks requests
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_node) && $stable(rsp_kind) && !req_ready));

endmodule

// File: tb/lpdir_entry_ctrl_bench.sv
module lpdir_entry_ctrl_bench;
  localparam int NODE_W = 6;
  localparam int NPTR   = 4;
  localparam int CNT_W  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [NODE_W-1:0] req_node = '0;
  logic req_ready;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [1:0] rsp_kind;
  logic [NODE_W-1:0] rsp_node;
  logic inv_valid, inv_ready = 1'b1;
  logic [NODE_W-1:0] inv_node;
  logic ack_valid = 1'b0;
  logic trap_req, trap_cause;
  logic [NODE_W-1:0] trap_node;
  logic trap_done = 1'b0, term_valid = 1'b0;
  logic [NODE_W-1:0] term_node = '0;
  logic [CNT_W-1:0] term_count = '0;
  logic [NPTR-1:0] dir_vld;
  logic [NPTR*NODE_W-1:0] dir_ptrs;
  logic meta_tow;

  always #2.5 clk = ~clk;

  lpdir_entry_ctrl #(.NODE_W(NODE_W), .NPTR(NPTR)) u_lpdir_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_node(req_node), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_node(rsp_node),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_node(inv_node),
    .ack_valid(ack_valid), .trap_req(trap_req), .trap_cause(trap_cause),
    .trap_node(trap_node), .trap_done(trap_done), .term_valid(term_valid),
    .term_node(term_node), .term_count(term_count), .dir_vld(dir_vld),
    .dir_ptrs(dir_ptrs), .meta_tow(meta_tow)
  );

  int checks = 0, fails = 0;
  int inv_total = 0;
  logic [NODE_W-1:0] inv_log [64];
  bit finished = 0;

  // model
  int mptr [NPTR];
  int mcnt = 0;
  bit mtow = 0;
  bit mexcl = 0;
  int mown = 0;

  always @(posedge clk) begin
    if (rst_n && inv_valid && inv_ready) begin
      inv_log[inv_total % 64] = inv_node;
      inv_total++;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic bit model_hit(input int n);
    for (int i = 0; i < mcnt; i++) if (mptr[i] == n) return 1;
    return 0;
  endfunction

  function automatic int ptr_at(input int slot);
    return int'(dir_ptrs[slot*NODE_W +: NODE_W]);
  endfunction

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic send_req(input int n, input bit wr);
    int t = 0;
    @(negedge clk);
    while (!req_ready && t < 100) begin @(negedge clk); t++; end
    req_valid = 1'b1; req_node = NODE_W'(n); req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic get_rsp(input int kind, input int n, input string rq);
    int t = 0;
    while (!rsp_valid && t < 60) begin @(negedge clk); t++; end
    chk(rsp_valid, rq, "rsp_valid", int'(rsp_valid), 1);
    chk(int'(rsp_kind) == kind, rq, "rsp_kind", int'(rsp_kind), kind);
    chk(int'(rsp_node) == n, rq, "rsp_node", int'(rsp_node), n);
  endtask

  task automatic acks(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); ack_valid = 1'b1;
      @(negedge clk); ack_valid = 1'b0;
    end
  endtask

  task automatic wait_invs(input int target, input string rq);
    int t = 0;
    while (inv_total < target && t < 60) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    chk(inv_total == target, rq, "invalidation count", inv_total, target);
  endtask

  task automatic expect_trap(input int cause, input int n, input string rq);
    chk(trap_req && int'(trap_cause) == cause, rq, "trap cause", trap_req ? int'(trap_cause) : -1, cause);
    chk(int'(trap_node) == n, rq, "trap node", int'(trap_node), n);
    chk(!rsp_valid && !req_ready, rq, "no response and stalled", int'(rsp_valid) + int'(req_ready), 0);
  endtask

  task automatic pulse_done;
    @(negedge clk); trap_done = 1'b1;
    @(negedge clk); trap_done = 1'b0;
  endtask

  task automatic terminate(input int n, input int cnt);
    @(negedge clk); term_valid = 1'b1; term_node = NODE_W'(n); term_count = CNT_W'(cnt);
    @(negedge clk); term_valid = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mcnt = 0; mtow = 0; mexcl = 0;
  endtask

  task automatic rand_step;
    int n, k, base;
    bit wr;
    n  = $urandom_range(0, 7);
    wr = ($urandom_range(0, 4) == 0);
    if (mexcl) begin
      if (n == mown) begin
        send_req(n, wr);
        get_rsp(wr ? 1 : 0, n, "R9");
      end else begin
        base = inv_total;
        send_req(n, wr);
        wait_invs(base + 1, "R9");
        chk(int'(inv_log[base % 64]) == mown, "R9", "owner invalidated", int'(inv_log[base % 64]), mown);
        acks(1);
        get_rsp(wr ? 1 : 0, n, "R9");
        if (wr) mown = n;
        else begin mexcl = 0; mcnt = 1; mptr[0] = n; end
      end
    end else if (!wr) begin
      send_req(n, 1'b0);
      if (model_hit(n)) get_rsp(0, n, "R2");
      else if (mcnt < NPTR) begin
        get_rsp(0, n, "R1");
        mptr[mcnt] = n; mcnt++;
      end else begin
        expect_trap(0, n, "R3");
        pulse_done();
        chk(dir_vld == '0 && meta_tow, "R4", "emptied and armed", int'(dir_vld), 0);
        mcnt = 0; mtow = 1;
      end
      if (!mexcl) chk($countones(dir_vld) == mcnt, "R1", "valid pointer count", $countones(dir_vld), mcnt);
    end else if (mtow) begin
      send_req(n, 1'b1);
      expect_trap(1, n, "R5");
      k = $urandom_range(0, 3);
      terminate(n, k);
      chk(!meta_tow && dir_vld == '0, "R6", "meta cleared", int'(meta_tow), 0);
      acks(k);
      get_rsp(1, n, "R6");
      mtow = 0; mcnt = 0; mexcl = 1; mown = n;
    end else begin
      base = inv_total;
      k = mcnt;
      send_req(n, 1'b1);
      wait_invs(base + k, "R7");
      acks(k);
      get_rsp(1, n, "R7");
      mcnt = 0; mexcl = 1; mown = n;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_up();
  end

  initial begin
    int base;
    void'($urandom(32'h5EED_0042));
    do_reset();
    // R11 reset state
    chk(dir_vld == '0, "R11", "dir_vld", int'(dir_vld), 0);
    chk(!meta_tow && !trap_req && !rsp_valid && !inv_valid, "R11", "idle outputs", int'(meta_tow) + int'(trap_req) + int'(rsp_valid) + int'(inv_valid), 0);
    chk(req_ready, "R11", "req_ready", int'(req_ready), 1);

    // R1 first reader
    send_req(3, 0); get_rsp(0, 3, "R1");
    chk(dir_vld == 4'b0001 && ptr_at(0) == 3, "R1", "slot0", ptr_at(0), 3);
    // R2 duplicate
    send_req(3, 0); get_rsp(0, 3, "R2");
    chk(dir_vld == 4'b0001, "R2", "no new slot", int'(dir_vld), 1);
    send_req(5, 0); get_rsp(0, 5, "R1");
    chk(ptr_at(1) == 5, "R2", "next free slot after duplicate", ptr_at(1), 5);
    send_req(7, 0); get_rsp(0, 7, "R1");
    send_req(9, 0); get_rsp(0, 9, "R1");
    send_req(3, 0); get_rsp(0, 3, "R2");
    chk(!trap_req && dir_vld == 4'b1111, "R2", "full, no trap", int'(trap_req), 0);
    // R3 overflow
    send_req(11, 0);
    expect_trap(0, 11, "R3");
    chk(ptr_at(3) == 9 && dir_vld == 4'b1111, "R3", "pointers visible", ptr_at(3), 9);
    repeat (3) @(negedge clk);
    chk(trap_req && !req_ready, "R3", "trap holds", int'(trap_req), 1);
    // R4 handler done
    pulse_done();
    chk(dir_vld == '0 && meta_tow && !trap_req && req_ready, "R4", "after trap_done", int'(dir_vld), 0);
    send_req(12, 0); get_rsp(0, 12, "R4");
    chk(dir_vld == 4'b0001 && ptr_at(0) == 12, "R4", "reallocation", ptr_at(0), 12);
    // R5 write under trap-on-write
    send_req(20, 1);
    expect_trap(1, 20, "R5");
    // R6 termination count 2
    terminate(20, 2);
    chk(dir_vld == '0 && !meta_tow && !trap_req, "R6", "termination state", int'(meta_tow), 0);
    acks(1);
    chk(!rsp_valid, "R6", "no grant after one ack", int'(rsp_valid), 0);
    // R8 busy during write transaction
    send_req(4, 0); get_rsp(2, 4, "R8");
    repeat (2) @(negedge clk);
    chk(!rsp_valid, "R8", "busy changed nothing", int'(rsp_valid), 0);
    acks(1);
    get_rsp(1, 20, "R6");
    // R9 exclusive handover
    send_req(20, 0); get_rsp(0, 20, "R9");
    base = inv_total;
    send_req(21, 1);
    wait_invs(base + 1, "R9");
    chk(int'(inv_log[base % 64]) == 20, "R9", "owner invalidated", int'(inv_log[base % 64]), 20);
    acks(1); get_rsp(1, 21, "R9");
    base = inv_total;
    send_req(22, 0);
    wait_invs(base + 1, "R9");
    acks(1); get_rsp(0, 22, "R9");
    chk(dir_vld == 4'b0001 && ptr_at(0) == 22, "R9", "shared with reader", ptr_at(0), 22);
    // R7 hardware write with back-pressure on invalidations (R10)
    send_req(23, 0); get_rsp(0, 23, "R1");
    send_req(24, 0); get_rsp(0, 24, "R1");
    inv_ready = 1'b0;
    base = inv_total;
    send_req(25, 1);
    repeat (3) @(negedge clk);
    chk(inv_valid && int'(inv_node) == 22, "R10", "inv held", int'(inv_node), 22);
    chk(dir_vld == '0, "R7", "pointers emptied", int'(dir_vld), 0);
    inv_ready = 1'b1;
    wait_invs(base + 3, "R7");
    chk(int'(inv_log[base % 64]) == 22 && int'(inv_log[(base + 1) % 64]) == 23 && int'(inv_log[(base + 2) % 64]) == 24,
        "R7", "order", int'(inv_log[(base + 2) % 64]), 24);
    acks(2);
    chk(!rsp_valid, "R7", "no grant before last ack", int'(rsp_valid), 0);
    acks(1); get_rsp(1, 25, "R7");
    // R10 response back-pressure
    rsp_ready = 1'b0;
    send_req(25, 0);
    repeat (3) @(negedge clk);
    chk(rsp_valid && int'(rsp_node) == 25 && !req_ready, "R10", "rsp held", int'(rsp_node), 25);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R10", "released", int'(rsp_valid), 0);
    // R6 zero count termination
    do_reset();
    for (int i = 0; i < 4; i++) begin send_req(i + 1, 0); get_rsp(0, i + 1, "R1"); end
    send_req(30, 0); expect_trap(0, 30, "R3");
    pulse_done();
    send_req(31, 1); expect_trap(1, 31, "R5");
    terminate(31, 0);
    get_rsp(1, 31, "R6");

    // random phase
    do_reset();
    for (int it = 0; it < 300; it++) rand_step();
    finish_up();
  end
endmodule